// File: doc/BRIEF.md
# Register-File Serial Bus Slave

This block is a two-wire serial bus slave that opens a 64-location byte space to a bus master. Locations 0 to 7 hold the clock and control registers and locations 8 to 63 are scratch RAM. The storage lives in a neighbouring block. This slave only produces write strobes with an address and data, and it presents a read address whose data it expects back in the same cycle. SCL and SDA arrive as raw inputs sampled by the system clock. The slave drives SDA only through an open-drain pull-low enable.

A transfer opens with START and the 7-bit slave address plus a direction bit. A write transfer first loads a word-address byte into an internal pointer. Every later byte is then stored at the pointer. A read transfer streams bytes from the pointer. It may be entered either by a repeated START after the word address, or directly, in which case it resumes wherever the pointer last stood. The pointer advances only during an acknowledge clock. A power-fail input overrides everything: it aborts the transfer, clears the pointer and deafens the slave to the bus.

Top module: `rtc_bus_slave`

## Requirements
- R1: The slave answers only a first byte whose upper seven bits are 1101000. Bit 0 is the direction: 0xD0 is a write and 0xD1 is a read. Any other first byte gets no acknowledge, SDA stays released, and the slave ignores the bus until the next START.
- R2: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. After a STOP the slave releases SDA and neither acknowledges nor writes until a new START.
- R3: In a write transfer, the byte after the address byte is loaded into the pointer, keeping its low 6 bits. Each following byte is stored at the pointer with exactly one single-cycle write strobe per byte.
- R4: The slave pulls SDA low during the acknowledge clock of the matching address byte, the word-address byte and every received data byte.
- R5: The pointer (visible on the read-address output) resets to 0. It advances by one only on an acknowledge clock: a received data byte, or a master-acknowledged read byte. It wraps from 63 to 0. A master not-acknowledge leaves it unchanged.
- R6: A read sends the byte at the pointer, MSB first. It keeps sending consecutive bytes while the master acknowledges. After a master not-acknowledge the slave releases SDA so the master can issue STOP.
- R7: A read addressed with 0xD1 directly after START begins at the pointer's current value. A repeated START after a word-address write switches the transfer to reading from that word address.
- R8: While power-fail is high, any transfer is abandoned, SDA is released, the pointer is held at 0, and no acknowledge or write strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| powerFail | input | 1 | High while supply is out of tolerance; aborts and blocks bus access |
| sclIn | input | 1 | Raw serial clock line |
| sdaIn | input | 1 | Raw serial data line as seen on the wire |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| regWrEn | output | 1 | Single-cycle write strobe to the register file |
| regWrAddr | output | 6 | Location written by regWrEn |
| regWrData | output | 8 | Byte written by regWrEn |
| regRdAddr | output | 6 | Current pointer, used as read address |
| regRdData | input | 8 | Byte at regRdAddr, returned combinationally |

## Verification
The hardest states to reach from the ports are the pointer's behaviour at the 63-to-0 boundary under both write and read bursts, and a power-fail that lands in the middle of a byte. The first is reached by setting the word address to 62 and streaming three bytes each way, so that the wrap and the unchanged pointer after a not-acknowledge both show on the read-address output. The second is reached by raising power-fail after the pointer has been loaded and then clocking a full byte and a full new transfer while it stays high. The bench then checks that no acknowledge or write appeared and that a later direct read resumes at location 0.

// File: rtl/bus_slave_pkg.sv
package bus_slave_pkg;

  typedef struct packed {
    logic loadPtr;
    logic incPtr;
    logic clrPtr;
    logic writeEn;
    logic loadTx;
    logic shiftTx;
  } dpCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKOUT,
    ST_TX,
    ST_ACKIN
  } slvState_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_WORD,
    K_DATA
  } rxKind_t;

endpackage

// File: rtl/bus_slave_sync.sv
module bus_slave_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/bus_slave_dp.sv
module bus_slave_dp
  import bus_slave_pkg::*;
#(
  parameter int PTR_W       = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtrl_t           ctl,
  input  logic [DATA_W-1:0] rdData,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaNow,
  output logic              txBit,
  output logic [DATA_W-1:0] rxByte,
  output logic [PTR_W-1:0]  ptr
);
  localparam int LINES = 2;

  logic [LINES-1:0] lineRaw;
  logic [LINES-1:0] lineSync;
  logic             sclPrev;
  logic             sdaPrev;
  logic             sclNow;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;

  assign lineRaw = {sdaIn, sclIn};

  for (genvar g = 0; g < LINES; g++) begin : gLineSync
    bus_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .din (lineRaw[g]),
      .dout(lineSync[g])
    );
  end

  assign sclNow = lineSync[0];
  assign sdaNow = lineSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rxShift <= '0;
    else if (sclRise) rxShift <= {rxShift[DATA_W-2:0], sdaNow};
  end
  assign rxByte = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ptr <= '0;
    else if (ctl.clrPtr)  ptr <= '0;
    else if (ctl.loadPtr) ptr <= rxShift[PTR_W-1:0];
    else if (ctl.incPtr)  ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txShift <= '1;
    else if (ctl.loadTx)  txShift <= rdData;
    else if (ctl.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b1};
  end
  assign txBit = txShift[DATA_W-1];

  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !stopDet) else $error("start followed by stop"); // R2
endmodule

// File: rtl/bus_slave_ctrl.sv
module bus_slave_ctrl
  import bus_slave_pkg::*;
#(
  parameter int            DATA_W     = 8,
  parameter logic [6:0]    SLAVE_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerFail,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaNow,
  input  logic              txBit,
  input  logic [DATA_W-1:0] rxByte,
  output dpCtrl_t           ctl,
  output logic              sdaDriveLow
);
  localparam int          BIT_W    = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  slvState_t         state;
  rxKind_t           kind;
  logic [BIT_W-1:0]  bitCnt;
  logic              rxFull;
  logic              isRead;
  logic              ackSeen;

  always_comb begin
    ctl = '0;
    if (powerFail) begin
      ctl.clrPtr = 1'b1;
    end else if (!startDet && !stopDet) begin
      unique case (state)
        ST_ACKOUT: begin
          if (sclRise && kind == K_WORD) ctl.loadPtr = 1'b1;
          if (sclRise && kind == K_DATA) begin
            ctl.writeEn = 1'b1;
            ctl.incPtr  = 1'b1;
          end
          if (sclFall && kind == K_ADDR && isRead) ctl.loadTx = 1'b1;
        end
        ST_TX:   if (sclFall) ctl.shiftTx = 1'b1;
        ST_ACKIN: begin
          if (sclRise && !sdaNow) ctl.incPtr = 1'b1;
          if (sclFall && ackSeen) ctl.loadTx = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kind    <= K_ADDR;
      bitCnt  <= '0;
      rxFull  <= 1'b0;
      isRead  <= 1'b0;
      ackSeen <= 1'b0;
    end else if (powerFail) begin
      state  <= ST_IDLE;
      rxFull <= 1'b0;
    end else if (startDet) begin
      state  <= ST_RX;
      kind   <= K_ADDR;
      bitCnt <= '0;
      rxFull <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
            rxFull <= (bitCnt == LAST_BIT);
          end else if (sclFall && rxFull) begin
            rxFull <= 1'b0;
            if (kind == K_ADDR) begin
              if (rxByte[DATA_W-1:1] == SLAVE_ADDR) begin
                isRead <= rxByte[0];
                state  <= ST_ACKOUT;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              state <= ST_ACKOUT;
            end
          end
        end
        ST_ACKOUT: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (kind == K_ADDR && isRead) begin
              state <= ST_TX;
            end else if (kind == K_ADDR) begin
              kind  <= K_WORD;
              state <= ST_RX;
            end else begin
              kind  <= K_DATA;
              state <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) state <= ST_ACKIN;
          end
        end
        ST_ACKIN: begin
          if (sclRise) ackSeen <= ~sdaNow;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= ackSeen ? ST_TX : ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaDriveLow = (state == ST_ACKOUT) || (state == ST_TX && !txBit);

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaDriveLow) else $error("SDA held after stop"); // R2
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaDriveLow) else $error("SDA held after start"); // R2
endmodule

// File: rtl/rtc_bus_slave.sv
module rtc_bus_slave
  import bus_slave_pkg::*;
#(
  parameter int         PTR_W       = 6,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] SLAVE_ADDR  = 7'h68
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerFail,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  output logic              regWrEn,
  output logic [PTR_W-1:0]  regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic [PTR_W-1:0]  regRdAddr,
  input  logic [DATA_W-1:0] regRdData
);
  dpCtrl_t           ctl;
  logic              sclRise, sclFall, startDet, stopDet, sdaNow, txBit;
  logic [DATA_W-1:0] rxByte;
  logic [PTR_W-1:0]  ptr;

  bus_slave_dp #(
    .PTR_W(PTR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .rdData(regRdData), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaNow(sdaNow),
    .txBit(txBit), .rxByte(rxByte), .ptr(ptr)
  );

  bus_slave_ctrl #(
    .DATA_W(DATA_W), .SLAVE_ADDR(SLAVE_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .powerFail(powerFail), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .sdaNow(sdaNow), .txBit(txBit), .rxByte(rxByte), .ctl(ctl),
    .sdaDriveLow(sdaDriveLow)
  );

  assign regWrEn   = ctl.writeEn;
  assign regWrAddr = ptr;
  assign regWrData = rxByte;
  assign regRdAddr = ptr;

  AST_PF_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |=> !sdaDriveLow) else $error("SDA driven in power fail"); // R8
  AST_PF_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |=> regRdAddr == '0) else $error("pointer kept in power fail"); // R8
  AST_PF_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |-> !regWrEn) else $error("write during power fail"); // R8
  AST_WRITE_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdAddr == PTR_W'($past(regWrAddr) + 1'b1)) else $error("pointer did not step"); // R5
  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn) else $error("write strobe longer than one cycle"); // R3
endmodule

// File: tb/rtc_bus_slave_tb.sv
module rtc_bus_slave_tb;
  localparam int HT = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       powerFail = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaLine;
  logic       sdaDriveLow;
  logic       regWrEn;
  logic [5:0] regWrAddr;
  logic [7:0] regWrData;
  logic [5:0] regRdAddr;
  logic [7:0] regRdData;
  logic [7:0] mem [64];
  int         nChecks = 0;
  int         nFail = 0;
  int         wrCount = 0;
  int         cyc = 0;

  always #5 clk = ~clk;

  assign sdaLine   = sdaM & ~sdaDriveLow;
  assign regRdData = mem[regRdAddr];

  rtc_bus_slave u_dut (
    .clk(clk), .rstN(rstN), .powerFail(powerFail), .sclIn(sclM),
    .sdaIn(sdaLine), .sdaDriveLow(sdaDriveLow), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .regRdAddr(regRdAddr),
    .regRdData(regRdData)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
    end else if (regWrEn) begin
      mem[regWrAddr] <= regWrData;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (regWrEn) wrCount <= wrCount + 1;
    if (cyc == 150000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startC();
    sdaM = 1'b1; gap(HT);
    sclM = 1'b1; gap(HT);
    sdaM = 1'b0; gap(HT);
    sclM = 1'b0; gap(HT);
  endtask

  task automatic stopC();
    sdaM = 1'b0; gap(HT);
    sclM = 1'b1; gap(HT);
    sdaM = 1'b1; gap(HT);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; gap(HT);
      sclM = 1'b1; gap(HT);
      sclM = 1'b0; gap(HT);
    end
    sdaM = 1'b1; gap(HT);
    sclM = 1'b1; gap(HT / 2);
    ackd = ~sdaLine;
    gap(HT / 2);
    sclM = 1'b0; gap(HT);
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; gap(HT);
      sclM = 1'b1; gap(HT / 2);
      b[i] = sdaLine;
      gap(HT / 2);
      sclM = 1'b0; gap(HT);
    end
    sdaM = ~giveAck; gap(HT);
    sclM = 1'b1; gap(HT);
    sclM = 1'b0; gap(HT);
    sdaM = 1'b1;
  endtask

  // {word address, data, expected location}
  localparam logic [21:0] VEC [6] = '{
    {8'h00, 8'h3C, 6'd0},
    {8'h07, 8'hA5, 6'd7},
    {8'h08, 8'h5A, 6'd8},
    {8'h3F, 8'hFF, 6'd63},
    {8'h45, 8'h81, 6'd5},
    {8'h20, 8'h00, 6'd32}
  };

  initial begin
    logic       a;
    logic [7:0] b;
    int         w0;

    gap(4);
    rstN = 1'b1;
    gap(4);
    chk("R5 reset pointer", regRdAddr, 0);
    chk("R2 reset SDA released", sdaDriveLow, 0);
    chk("R3 reset no write", regWrEn, 0);

    // table walk: write one byte, read it back via repeated START
    for (int v = 0; v < 6; v++) begin
      startC();
      sendByte(8'hD0, a); chk("R1 write address ack", a, 1);
      sendByte(VEC[v][21:14], a); chk("R4 word address ack", a, 1);
      sendByte(VEC[v][13:6], a); chk("R4 data ack", a, 1);
      stopC();
      chk("R3 stored at word address", mem[VEC[v][5:0]], VEC[v][13:6]);
      startC();
      sendByte(8'hD0, a);
      sendByte(VEC[v][21:14], a);
      startC();
      sendByte(8'hD1, a); chk("R7 read address ack after repeated start", a, 1);
      recvByte(1'b0, b); chk("R6 read data", b, VEC[v][13:6]);
      stopC();
      chk("R5 no advance on nack", regRdAddr, VEC[v][5:0]);
    end

    // wrong slave address
    w0 = wrCount;
    startC();
    sendByte(8'hA0, a); chk("R1 foreign address not acked", a, 0);
    sendByte(8'h00, a); chk("R1 ignored after mismatch", a, 0);
    stopC();
    chk("R1 no write after mismatch", wrCount, w0);

    // burst write across the top of the space
    w0 = wrCount;
    startC();
    sendByte(8'hD0, a);
    sendByte(8'h3E, a);
    sendByte(8'h11, a); sendByte(8'h22, a); sendByte(8'h33, a);
    chk("R4 last burst byte ack", a, 1);
    stopC();
    chk("R3 one strobe per byte", wrCount - w0, 3);
    chk("R5 write at 62", mem[62], 8'h11);
    chk("R5 write at 63", mem[63], 8'h22);
    chk("R5 wrap write at 0", mem[0], 8'h33);
    chk("R5 pointer after wrap", regRdAddr, 1);

    // burst read across the top
    startC();
    sendByte(8'hD0, a); sendByte(8'h3E, a);
    startC();
    sendByte(8'hD1, a);
    recvByte(1'b1, b); chk("R6 burst read 62", b, 8'h11);
    recvByte(1'b1, b); chk("R6 burst read 63", b, 8'h22);
    recvByte(1'b0, b); chk("R6 burst read wrap 0", b, 8'h33);
    gap(4);
    chk("R6 SDA released after nack", sdaDriveLow, 0);
    stopC();
    chk("R5 read wrap and nack hold", regRdAddr, 0);

    // read without word-address phase
    startC();
    sendByte(8'hD0, a); sendByte(8'h01, a);
    sendByte(8'hB1, a); sendByte(8'hB2, a); sendByte(8'hB3, a);
    stopC();
    startC();
    sendByte(8'hD0, a); sendByte(8'h02, a);
    stopC();
    startC();
    sendByte(8'hD1, a); chk("R7 direct read ack", a, 1);
    recvByte(1'b1, b); chk("R7 direct read starts at pointer", b, 8'hB2);
    recvByte(1'b0, b); chk("R6 next byte", b, 8'hB3);
    stopC();
    chk("R5 advance only on acked byte", regRdAddr, 3);

    // STOP mid transfer
    w0 = wrCount;
    startC();
    sendByte(8'hD0, a); sendByte(8'h30, a);
    stopC();
    chk("R3 word address loaded", regRdAddr, 6'h30);
    sendByte(8'h55, a); chk("R2 no ack after stop", a, 0);
    chk("R2 no write after stop", wrCount, w0);
    stopC();

    // power fail mid transfer
    w0 = wrCount;
    startC();
    sendByte(8'hD0, a); sendByte(8'h10, a);
    chk("R3 pointer loaded before abort", regRdAddr, 6'h10);
    powerFail = 1'b1;
    gap(2);
    chk("R8 pointer cleared", regRdAddr, 0);
    chk("R8 SDA released", sdaDriveLow, 0);
    sendByte(8'h77, a); chk("R8 no ack while failing", a, 0);
    stopC();
    startC();
    sendByte(8'hD0, a); chk("R8 address ignored while failing", a, 0);
    sendByte(8'h05, a);
    sendByte(8'h99, a);
    stopC();
    chk("R8 no write while failing", wrCount, w0);
    powerFail = 1'b0;
    gap(4);
    startC();
    sendByte(8'hD1, a); chk("R8 acks again after recovery", a, 1);
    recvByte(1'b0, b); chk("R8 read resumes at 0", b, 8'h33);
    stopC();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule